// File: doc/BRIEF.md
# Rectangle Raster-Operation Blit Engine

The engine applies one rectangle operation to a small pixel store inside the block each time it is started. The store holds 8 bits per pixel. A screen-to-screen copy, a solid fill and an area invert all use the same datapath: every output bit comes from a 16-entry truth table. The table is indexed by the foreground, source and destination bits of that pixel, so only the ALU word changes from one operation to the next. A draw offset is added to every coordinate. A clip rectangle decides which destination pixels may actually be written.

Software loads the corner, offset, clip, foreground and ALU registers through a simple write port, then writes the start register. The engine visits the destination rectangle one pixel per clock. While it runs, a status word shows it busy, and further starts or register writes are refused and flagged as a full queue. A host pixel port loads and reads the store directly while the engine is idle.

Top module: `raster_blit`

## Requirements
- R1: After reset, status words 17, 18 and 19 read zero. The clip rectangle covers the whole store (0,0)-(FB_W-1,FB_H-1). Offsets are zero. Host pixel writes at idle land in the store and read back on the pixel port.
- R2: With ALU word 0xCCCC the destination rectangle (lower-left x,y at registers 4,5, upper-right at 6,7, both corners inclusive) receives the source pixels. The source origin is the source lower-left corner at registers 0,1, and destination pixel (dx0+i, dy0+j) takes source (sx0+i, sy0+j). Each result bit i is ALU[{fg[i],1,src[i],dst[i]}], the 4-bit index ordered from most to least significant bit.
- R3: With ALU word 0xFF00 every written pixel equals the foreground register (14). Any other ALU word (register 15, low 16 bits) follows the R2 index formula, for example 0x6666 gives src XOR dst.
- R4: With ALU word 0x5555 every written pixel becomes the bitwise inverse of its old value.
- R5: A destination pixel is written only if its screen coordinate lies inside the inclusive clip rectangle (min x,y at registers 10,11, max x,y at 12,13) and inside the store. Other pixels keep their value.
- R6: The x and y offsets (registers 8,9) are added modulo 2^CW to both source and destination coordinates before clipping and addressing.
- R7: A copy whose source and destination overlap gives the same result as copying from an untouched snapshot of the source. This holds for the destination above, below, left of and right of the source.
- R8: A write of any value to register 16 starts the operation on a non-empty rectangle. Status word 17 then reads bit 28 set for exactly (w+1)*(h+1) cycles, where w = dx1-dx0 and h = dy1-dy0.
- R9: While busy, a start write sets bit 29 in status words 18 and 19 and is otherwise ignored. Register writes and host pixel writes are also ignored while busy. Bit 29 clears when the operation completes.
- R10: A rectangle with dx1 < dx0 or dy1 < dy0 never sets the busy bit and writes no pixel.
- R11: A source pixel reads as 0 when it falls outside the store, or when its offset from the source lower-left exceeds (sx1-sx0) in x or (sy1-sy0) in y. Registers 2 and 3 hold sx1 and sy1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for writes and status reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Status word for the address on reg_addr (combinational) |
| px_we | input | 1 | Host pixel write strobe, honoured only while idle |
| px_x | input | XB | Host pixel x |
| px_y | input | YB | Host pixel y |
| px_wdata | input | 8 | Host pixel write data |
| px_rdata | output | 8 | Pixel at (px_x, px_y), combinational |

## Verification
The assertions assume that reset is held low at the start and that a start write is a single-cycle strobe on register 16. They also assume that the clip registers are written only while idle, so the clip window seen with each write is the one that was programmed. The bench drives every register and pixel write on the falling edge and restarts the engine only after it has polled the busy bit low. The one exception is the deliberate queue-full test. Rectangles are kept small, so no coordinate wraps past 2^CW; the overlap checks therefore compare against a plain snapshot of the source.

// File: rtl/raster_blit.sv
`timescale 1ns/1ps
module raster_blit #(
  parameter int XB = 4,
  parameter int YB = 4,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          px_we,
  input  logic [XB-1:0] px_x,
  input  logic [YB-1:0] px_y,
  input  logic [7:0]    px_wdata,
  output logic [7:0]    px_rdata
);
  localparam int FB_W  = 1 << XB;
  localparam int FB_H  = 1 << YB;
  localparam int DEPTH = FB_W * FB_H;
  localparam logic [4:0] A_SX0 = 5'd0,  A_SY0 = 5'd1,  A_SX1 = 5'd2,  A_SY1 = 5'd3;
  localparam logic [4:0] A_DX0 = 5'd4,  A_DY0 = 5'd5,  A_DX1 = 5'd6,  A_DY1 = 5'd7;
  localparam logic [4:0] A_OX  = 5'd8,  A_OY  = 5'd9;
  localparam logic [4:0] A_CX0 = 5'd10, A_CY0 = 5'd11, A_CX1 = 5'd12, A_CY1 = 5'd13;
  localparam logic [4:0] A_FG  = 5'd14, A_ALU = 5'd15, A_GO  = 5'd16;
  localparam logic [4:0] A_GST = 5'd17, A_BST = 5'd18, A_DST = 5'd19;

  logic [7:0] mem [DEPTH];

  logic [CW-1:0] sx0, sy0, sx1, sy1, dx0, dy0, dx1, dy1, ox, oy;
  logic [CW-1:0] cminx, cminy, cmaxx, cmaxy;
  logic [7:0]    fg;
  logic [15:0]   alu;
  logic          busy, full;
  logic [CW-1:0] ix, iy;

  logic [CW-1:0] w, h, rx, ry, tx, ty, ux, uy;
  logic          empty, rev_x, rev_y, t_in, u_in, clip_ok, eng_we, last, start;
  logic [XB+YB-1:0] taddr, uaddr;
  logic [7:0]    dpix, spix, npix;

  assign start = reg_we && reg_addr == A_GO;
  assign empty = (dx1 < dx0) || (dy1 < dy0);
  assign w     = dx1 - dx0;
  assign h     = dy1 - dy0;
  assign rev_x = dx0 > sx0;
  assign rev_y = dy0 > sy0;
  assign rx    = rev_x ? w - ix : ix;
  assign ry    = rev_y ? h - iy : iy;
  assign tx    = dx0 + rx + ox;
  assign ty    = dy0 + ry + oy;
  assign ux    = sx0 + rx + ox;
  assign uy    = sy0 + ry + oy;
  assign t_in  = tx < CW'(FB_W) && ty < CW'(FB_H);
  assign u_in  = ux < CW'(FB_W) && uy < CW'(FB_H) &&
                 rx <= CW'(sx1 - sx0) && ry <= CW'(sy1 - sy0);
  assign clip_ok = tx >= cminx && tx <= cmaxx && ty >= cminy && ty <= cmaxy;
  assign taddr = {ty[YB-1:0], tx[XB-1:0]};
  assign uaddr = {uy[YB-1:0], ux[XB-1:0]};
  assign dpix  = mem[taddr];
  assign spix  = u_in ? mem[uaddr] : 8'h00;
  assign eng_we = busy && t_in && clip_ok;
  assign last  = ix == w && iy == h;
  assign px_rdata = mem[{px_y, px_x}];

  always_comb
    for (int i = 0; i < 8; i++)
      npix[i] = alu[{fg[i], 1'b1, spix[i], dpix[i]}];

  always_comb
    case (reg_addr)
      A_GST:        reg_rdata = {3'b000, busy, 28'h0};
      A_BST, A_DST: reg_rdata = {2'b00, full, 29'h0};
      default:      reg_rdata = 32'h0;
    endcase

  logic unused_bits;
  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk)
    if (eng_we) mem[taddr] <= npix;
    else if (px_we && !busy) mem[{px_y, px_x}] <= px_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {sx0, sy0, sx1, sy1, dx0, dy0, dx1, dy1, ox, oy} <= '0;
      cminx <= '0;
      cminy <= '0;
      cmaxx <= CW'(FB_W - 1);
      cmaxy <= CW'(FB_H - 1);
      fg    <= '0;
      alu   <= '0;
    end else if (reg_we && !busy)
      case (reg_addr)
        A_SX0: sx0   <= reg_wdata[CW-1:0];
        A_SY0: sy0   <= reg_wdata[CW-1:0];
        A_SX1: sx1   <= reg_wdata[CW-1:0];
        A_SY1: sy1   <= reg_wdata[CW-1:0];
        A_DX0: dx0   <= reg_wdata[CW-1:0];
        A_DY0: dy0   <= reg_wdata[CW-1:0];
        A_DX1: dx1   <= reg_wdata[CW-1:0];
        A_DY1: dy1   <= reg_wdata[CW-1:0];
        A_OX:  ox    <= reg_wdata[CW-1:0];
        A_OY:  oy    <= reg_wdata[CW-1:0];
        A_CX0: cminx <= reg_wdata[CW-1:0];
        A_CY0: cminy <= reg_wdata[CW-1:0];
        A_CX1: cmaxx <= reg_wdata[CW-1:0];
        A_CY1: cmaxy <= reg_wdata[CW-1:0];
        A_FG:  fg    <= reg_wdata[7:0];
        A_ALU: alu   <= reg_wdata[15:0];
        default: ;
      endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy <= 1'b0;
      full <= 1'b0;
      ix   <= '0;
      iy   <= '0;
    end else if (busy) begin
      if (last) begin
        busy <= 1'b0;
        full <= 1'b0;
      end else begin
        if (start) full <= 1'b1;
        if (ix == w) begin
          ix <= '0;
          iy <= iy + 1'b1;
        end else
          ix <= ix + 1'b1;
      end
    end else if (start && !empty) begin
      busy <= 1'b1;
      ix   <= '0;
      iy   <= '0;
    end
endmodule

// File: rtl/raster_blit_chk.sv
`timescale 1ns/1ps
module raster_blit_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          full,
  input logic          start,
  input logic          eng_we,
  input logic [CW-1:0] tx,
  input logic [CW-1:0] ty,
  input logic [CW-1:0] cminx,
  input logic [CW-1:0] cminy,
  input logic [CW-1:0] cmaxx,
  input logic [CW-1:0] cmaxy
);
  assert_full_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> busy);
  assert_start_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> full || !busy);
  assert_done_clears_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !full);
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_write_in_clip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_we |-> tx >= cminx && tx <= cmaxx && ty >= cminy && ty <= cmaxy);
endmodule

bind raster_blit raster_blit_chk #(.CW(CW)) u_chk (.*);

// File: tb/raster_blit_tb.sv
`timescale 1ns/1ps
module raster_blit_tb;
  logic        clk = 0, rst_n = 0;
  logic        reg_we = 0, px_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [3:0]  px_x = 0, px_y = 0;
  logic [7:0]  px_wdata = 0, px_rdata;

  raster_blit u_dut (.*);

  always #4 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] snap [16][16];
  logic [7:0] expm [16][16];
  int g_sx0, g_sy0, g_sx1, g_sy1, g_dx0, g_dy0, g_dx1, g_dy1;
  int g_ox, g_oy, g_cx0, g_cy0, g_cx1, g_cy1, g_fg, g_alu;
  int exp_cyc;
  longint t0;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    reg_addr = 5'(a);
    #1 d = reg_rdata;
  endtask

  task automatic pwr(int x, int y, int v);
    @(negedge clk);
    px_we = 1; px_x = 4'(x); px_y = 4'(y); px_wdata = 8'(v);
    @(negedge clk);
    px_we = 0;
  endtask

  function automatic logic [7:0] rop(logic [7:0] f, logic [7:0] s, logic [7:0] d, logic [15:0] a);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = a[{f[i], 1'b1, s[i], d[i]}];
    return r;
  endfunction

  task automatic pattern(int seed);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        snap[y][x] = 8'((x * 7 + y * 29 + seed) ^ (x << 4));
        pwr(x, y, snap[y][x]);
      end
  endtask

  task automatic model();
    int w, h, tx, ty, ux, uy;
    logic [7:0] sv;
    expm = snap;
    exp_cyc = 0;
    if (g_dx1 < g_dx0 || g_dy1 < g_dy0) return;
    w = g_dx1 - g_dx0; h = g_dy1 - g_dy0;
    exp_cyc = (w + 1) * (h + 1);
    for (int ry = 0; ry <= h; ry++)
      for (int rx = 0; rx <= w; rx++) begin
        tx = (g_dx0 + rx + g_ox) & 255; ty = (g_dy0 + ry + g_oy) & 255;
        ux = (g_sx0 + rx + g_ox) & 255; uy = (g_sy0 + ry + g_oy) & 255;
        if (tx < 16 && ty < 16 && tx >= g_cx0 && tx <= g_cx1 && ty >= g_cy0 && ty <= g_cy1) begin
          sv = (ux < 16 && uy < 16 && rx <= ((g_sx1 - g_sx0) & 255) &&
                ry <= ((g_sy1 - g_sy0) & 255)) ? snap[uy][ux] : 8'h00;
          expm[ty][tx] = rop(8'(g_fg), sv, snap[ty][tx], 16'(g_alu));
        end
      end
  endtask

  task automatic compare(string req);
    int bad = 0, fx = 0, fy = 0;
    logic [7:0] fa = 0, fe = 0;
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        px_x = 4'(x); px_y = 4'(y);
        #1;
        if (px_rdata !== expm[y][x]) begin
          if (bad == 0) begin fx = x; fy = y; fa = px_rdata; fe = expm[y][x]; end
          bad++;
        end
      end
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: pixel (%0d,%0d) actual=%0h expected=%0h (%0d wrong)", req, fx, fy, fa, fe, bad);
    end
    snap = expm;
  endtask

  task automatic launch();
    wr(16, 1);
    t0 = $time;
  endtask

  task automatic wait_idle(output int cyc);
    logic [31:0] d;
    int n = 0;
    rd(17, d);
    while (d[28] && n < 5000) begin
      @(negedge clk); n++;
      rd(17, d);
    end
    cyc = int'(($time - t0) / 8);
  endtask

  task automatic run(string req);
    int cyc;
    wr(0, g_sx0); wr(1, g_sy0); wr(2, g_sx1); wr(3, g_sy1);
    wr(4, g_dx0); wr(5, g_dy0); wr(6, g_dx1); wr(7, g_dy1);
    wr(8, g_ox);  wr(9, g_oy);
    wr(10, g_cx0); wr(11, g_cy0); wr(12, g_cx1); wr(13, g_cy1);
    wr(14, g_fg); wr(15, g_alu);
    model();
    launch();
    wait_idle(cyc);
    check({req, " R8 busy cycles"}, cyc, exp_cyc);
    compare(req);
  endtask

  task automatic rect(int sx0, int sy0, int sx1, int sy1, int dx0, int dy0, int dx1, int dy1);
    g_sx0 = sx0; g_sy0 = sy0; g_sx1 = sx1; g_sy1 = sy1;
    g_dx0 = dx0; g_dy0 = dy0; g_dx1 = dx1; g_dy1 = dy1;
  endtask

  initial begin
    #1_200_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int cyc;
    int alus [8] = '{16'hCCCC, 16'hFF00, 16'h5555, 16'h6666, 16'h8888, 16'hEEEE, 16'h0000, 16'hFFFF};
    #20 rst_n = 1;
    @(negedge clk);
    rd(17, d); check("R1 global status", d, 0);
    rd(18, d); check("R1 blit status", d, 0);
    rd(19, d); check("R1 draw status", d, 0);
    pattern(3);
    expm = snap; compare("R1 host store");

    g_sx0 = 0; g_sy0 = 0; g_sx1 = 0; g_sy1 = 0; g_ox = 0; g_oy = 0;
    g_cx0 = 0; g_cy0 = 0; g_cx1 = 15; g_cy1 = 15;
    rect(0, 0, 0, 0, 0, 0, 15, 15); g_fg = 8'h5A; g_alu = 16'hFF00;
    wr(6, 15); wr(7, 15); wr(14, g_fg); wr(15, g_alu);
    model(); launch(); wait_idle(cyc);
    check("R1 R8 default-clip fill cycles", cyc, 256);
    compare("R1 default clip and offset, R3 fill");

    pattern(11);
    for (int k = 0; k < 8; k++) begin
      rect(1, 2, 5, 6, 8 + (k % 3), 9, 12 + (k % 3), 13);
      g_fg = (8'h3C ^ (k * 37)) & 255; g_alu = alus[k];
      run(k == 0 ? "R2 copy" : k == 2 ? "R4 invert" : "R3 alu word");
    end

    pattern(40);
    g_alu = 16'h5555; rect(0, 0, 15, 15, 0, 0, 15, 15);
    run("R4 full invert");

    g_cx0 = 3; g_cy0 = 4; g_cx1 = 9; g_cy1 = 7; g_fg = 8'hA5; g_alu = 16'hFF00;
    rect(0, 0, 15, 15, 0, 0, 15, 15);
    run("R5 clip fill");
    g_alu = 16'hCCCC; rect(0, 0, 15, 15, 2, 1, 12, 10);
    run("R5 clip copy");
    g_cx0 = 0; g_cy0 = 0; g_cx1 = 15; g_cy1 = 15;

    g_ox = 2; g_oy = 3; rect(0, 0, 5, 4, 7, 6, 12, 10);
    run("R6 offset copy");
    g_ox = 0; g_oy = 0;

    pattern(77);
    rect(2, 2, 9, 9, 3, 4, 10, 11); run("R7 overlap dst up-right");
    rect(3, 4, 10, 11, 1, 2, 8, 9); run("R7 overlap dst down-left");
    rect(2, 5, 12, 7, 4, 5, 14, 7); run("R7 overlap same rows right");
    rect(4, 8, 14, 10, 1, 8, 11, 10); run("R7 overlap same rows left");

    rect(0, 0, 15, 15, 9, 2, 4, 6); g_alu = 16'hFF00;
    run("R10 empty x");
    rect(0, 0, 15, 15, 2, 9, 6, 4);
    run("R10 empty y");

    g_alu = 16'hCCCC; rect(1, 1, 2, 2, 6, 6, 10, 10);
    run("R11 source bounded by source rect");
    rect(13, 12, 15, 15, 2, 2, 6, 6);
    run("R11 source beyond store");

    pattern(5);
    g_fg = 8'h3E; g_alu = 16'hFF00; rect(0, 0, 15, 15, 2, 2, 9, 9);
    wr(4, g_dx0); wr(5, g_dy0); wr(6, g_dx1); wr(7, g_dy1); wr(14, g_fg); wr(15, g_alu);
    model();
    launch();
    wr(16, 1);
    rd(18, d); check("R9 blit full flag", d[29], 1);
    rd(19, d); check("R9 draw full flag", d[29], 1);
    wr(14, 8'h81);
    pwr(0, 0, 8'hEE);
    wait_idle(cyc);
    check("R9 ignored start keeps R8 length", cyc, 64);
    rd(18, d); check("R9 full cleared", d, 0);
    rd(19, d); check("R9 draw full cleared", d, 0);
    compare("R9 ignored fg and pixel writes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule